// File: doc/BRIEF.md
# CRC-4 Multiframe Alignment Detector

This block sits behind an E1 basic frame aligner and locates the 16-frame CRC-4 multiframe boundary. Once the basic aligner reports frame alignment, the detector watches bit 1 of timeslot 0 in every non-alignment (odd) frame. It looks for the six-bit marker 001011, which occupies the odd frames 1 through 11 of each multiframe. When a candidate marker is seen, the detector re-phases its own frame counter so that the frame just received becomes frame 11. It then waits one full multiframe for a second, error-free marker in the same place.

Two consecutive good markers declare CRC-4 multiframe sync. The sync status is active low. The block also reports the frame number within the multiframe, from 0 to 15. A one-cycle strobe marks every frame 11 that completes a valid marker, and a downstream CRC-interworking controller uses it. Losing basic alignment drops sync at once and starts the search again from an empty history.

Top module: `crc4mf_detector`

## Requirements
- R1: After reset, and for as long as `basic_sync_i` is 0, `crc_sync_n_o` is 1, `mf_frame_num_o` is 0 and `mf_pattern_pulse_o` is 0, whatever the frame strobes and data bits.
- R2: Only strobes with `frame_nfas_i` = 1 (odd, non-alignment frames) contribute a bit to the marker search. The `ts0_bit1_i` value on strobes with `frame_nfas_i` = 0 has no effect.
- R3: While searching, six collected bits equal to 0,0,1,0,1,1 (oldest first; oldest is frame 1, newest is frame 11) form a candidate. In the cycle after that strobe, `mf_frame_num_o` reads 11.
- R4: With `basic_sync_i` = 1, `mf_frame_num_o` advances by one modulo 16 on each strobe that does not re-phase it, and holds between strobes.
- R5: A candidate followed exactly 16 strobes later by a second error-free marker drives `crc_sync_n_o` to 0 in the cycle after the second frame-11 strobe. A single marker never does.
- R6: If the marker expected one multiframe after a candidate contains any wrong bit, sync is not declared and the search resumes. A later good marker is then only a new candidate and needs its own confirmation.
- R7: `mf_pattern_pulse_o` is high for exactly the one cycle after any frame-11 strobe that completes a valid marker (candidate, confirmation or while locked), and is 0 otherwise.
- R8: One cycle after `basic_sync_i` falls, `crc_sync_n_o` is 1, `mf_frame_num_o` is 0 and all collected bits are discarded.
- R9: After a restart, fewer than six collected bits never form a candidate, even if they match the tail of the marker.
- R10: Once locked, a multiframe with an errored marker gives no pulse but leaves `crc_sync_n_o` at 0. Only loss of basic alignment clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| basic_sync_i | input | 1 | 1 while the basic frame aligner holds alignment |
| frame_strobe_i | input | 1 | One-cycle strobe per received frame, qualifying the two inputs below |
| frame_nfas_i | input | 1 | 1 when the strobed frame is a non-alignment (odd) frame |
| ts0_bit1_i | input | 1 | Bit 1 of timeslot 0 of the strobed frame |
| crc_sync_n_o | output | 1 | CRC-4 multiframe sync, 0 = synchronised |
| mf_frame_num_o | output | 4 | Number of the most recently strobed frame within the multiframe |
| mf_pattern_pulse_o | output | 1 | One-cycle pulse after each frame 11 carrying a valid marker |

## Verification
A wrong bit in the marker history shows up as a missing or spurious pulse, at the latest on the next frame-11 strobe, which is no more than 16 strobes away. A mis-phased frame counter is visible on the frame-number port in the cycle after the strobe. It also moves the marker check to the wrong frame, so the confirmation either fails or fires early within one multiframe. A wrong state in the alignment machine surfaces on the sync port when a second marker arrives, or when basic alignment drops. The directed scenarios place the frame number just before and just after re-phasing. They corrupt single marker bits before and after lock, and they feed a five-bit tail that would match against a zero-filled history.

// File: rtl/crc4mf_pkg.sv
// Package: shared types for the CRC-4 multiframe alignment detector.
// Assumes: nothing beyond IEEE 1800-2017.
package crc4mf_pkg;

    // Alignment progress of the multiframe search.
    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } crc4mf_state_e;

endpackage

// File: rtl/crc4mf_bit_window.sv
// Module: crc4mf_bit_window
// Keeps the last PAT_BITS marker-carrying bits (oldest in the MSB) and a
// saturating count of how many bits have been collected since the last clear.
// hit_o is combinational: it is high in the cycle where the incoming bit
// completes a full window equal to PATTERN.
// Assumes: shift_i is only high on non-alignment frame strobes.
module crc4mf_bit_window #(
    parameter int                  PAT_BITS = 6,
    parameter logic [PAT_BITS-1:0] PATTERN  = 6'b001011,
    parameter int                  FILL_W   = $clog2(PAT_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic hit_o
);

    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(PAT_BITS);
    localparam logic [FILL_W-1:0] FILL_PRE = FILL_W'(PAT_BITS - 1);

    logic [PAT_BITS-1:0] window_q;
    logic [PAT_BITS-1:0] window_nxt;
    logic [FILL_W-1:0]   fill_q;
    logic                full_after;

    // Window contents once the incoming bit is appended.
    always_comb begin
        window_nxt = {window_q[PAT_BITS-2:0], bit_i};
        full_after = (fill_q >= FILL_PRE);
        hit_o      = shift_i && full_after && (window_nxt == PATTERN);
    end

    // History register and fill count; cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            window_q <= '0;
            fill_q   <= '0;
        end else if (shift_i) begin
            window_q <= window_nxt;
            if (fill_q != FILL_MAX) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // R9: the fill count never runs past the window length.
    p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_MAX);

    // R8: a restart empties the history.
    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (fill_q == '0));

endmodule

// File: rtl/crc4mf_frame_ctr.sv
// Module: crc4mf_frame_ctr
// Frame counter within the multiframe. It steps once per frame strobe,
// can be loaded with a given frame number (re-phasing), and is forced to
// zero while clear_i is high. num_next_o is the value the next step would give.
// Assumes: MF_FRAMES >= 2.
module crc4mf_frame_ctr #(
    parameter int MF_FRAMES = 16,
    parameter int NUM_W     = $clog2(MF_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [NUM_W-1:0] load_val_i,
    output logic [NUM_W-1:0] num_o,
    output logic [NUM_W-1:0] num_next_o
);

    localparam logic [NUM_W-1:0] LAST = NUM_W'(MF_FRAMES - 1);

    logic [NUM_W-1:0] num_q;

    // Successor frame number with wrap at the multiframe end.
    always_comb begin
        num_next_o = (num_q == LAST) ? '0 : num_q + 1'b1;
        num_o      = num_q;
    end

    // Counter register: clear wins, then load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            num_q <= '0;
        end else if (load_i) begin
            num_q <= load_val_i;
        end else if (step_i) begin
            num_q <= num_next_o;
        end
    end

    // R4: the last frame of a multiframe is followed by frame zero.
    p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !clear_i && num_q == LAST) |=> (num_q == '0));

endmodule

// File: rtl/crc4mf_align_fsm.sv
// Module: crc4mf_align_fsm
// Search / confirm / locked sequencer. In search it accepts the first
// full-window hit as a candidate and asks for the counter to be re-phased.
// In confirm it checks the window at the next frame-11 strobe and either
// locks or returns to search. Once locked it stays locked until clear_i.
// Every accepted marker produces a registered one-cycle pulse.
// Assumes: hit_i is already qualified by a non-alignment frame strobe.
module crc4mf_align_fsm
    import crc4mf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          hit_i,
    input  logic          nfas_strobe_i,
    input  logic          at_check_i,
    output logic          load_o,
    output logic          pulse_o,
    output logic          sync_n_o,
    output crc4mf_state_e state_o
);

    crc4mf_state_e state_q;
    crc4mf_state_e state_nxt;
    logic          pulse_d;
    logic          pulse_q;
    logic          sync_n_q;
    logic          check_now;

    // Next-state, re-phase request and pulse decision.
    always_comb begin
        state_nxt = state_q;
        load_o    = 1'b0;
        pulse_d   = 1'b0;
        check_now = nfas_strobe_i && at_check_i;
        case (state_q)
            ST_SEARCH: begin
                if (hit_i) begin
                    load_o    = 1'b1;
                    pulse_d   = 1'b1;
                    state_nxt = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (check_now) begin
                    if (hit_i) begin
                        pulse_d   = 1'b1;
                        state_nxt = ST_LOCKED;
                    end else begin
                        state_nxt = ST_SEARCH;
                    end
                end
            end
            ST_LOCKED: begin
                if (check_now && hit_i) begin
                    pulse_d = 1'b1;
                end
            end
            default: state_nxt = ST_SEARCH;
        endcase
        if (clear_i) begin
            state_nxt = ST_SEARCH;
            load_o    = 1'b0;
            pulse_d   = 1'b0;
        end
    end

    // State, pulse and active-low sync registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_SEARCH;
            pulse_q  <= 1'b0;
            sync_n_q <= 1'b1;
        end else begin
            state_q  <= state_nxt;
            pulse_q  <= pulse_d;
            sync_n_q <= (state_nxt != ST_LOCKED);
        end
    end

    assign pulse_o  = pulse_q;
    assign sync_n_o = sync_n_q;
    assign state_o  = state_q;

    // R5: lock is never reached straight from search.
    p_no_skip_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |=> (state_q != ST_LOCKED));

    // R8: loss of basic alignment returns to search.
    p_loss_to_search_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state_q == ST_SEARCH));

endmodule

// File: rtl/crc4mf_detector.sv
// Module: crc4mf_detector (top)
// CRC-4 multiframe alignment detector. It collects timeslot-0 bit 1 of
// non-alignment frames, finds the six-bit marker, re-phases the frame counter
// to the marker's last frame and declares active-low sync after two
// consecutive good markers. Loss of basic alignment restarts everything.
// Assumes: frame strobes are one cycle wide and at least one cycle apart is
// not required; inputs are synchronous to clk.
module crc4mf_detector #(
    parameter int                  MF_FRAMES   = 16,
    parameter int                  PAT_BITS    = 6,
    parameter logic [PAT_BITS-1:0] PATTERN     = 6'b001011,
    parameter int                  CHECK_FRAME = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       basic_sync_i,
    input  logic       frame_strobe_i,
    input  logic       frame_nfas_i,
    input  logic       ts0_bit1_i,
    output logic       crc_sync_n_o,
    output logic [3:0] mf_frame_num_o,
    output logic       mf_pattern_pulse_o
);

    import crc4mf_pkg::*;

    localparam int               NUM_W   = $clog2(MF_FRAMES);
    localparam int               FILL_W  = $clog2(PAT_BITS + 1);
    localparam logic [NUM_W-1:0] CHK_NUM = NUM_W'(CHECK_FRAME);

    logic             restart;
    logic             step;
    logic             nfas_strobe;
    logic             win_hit;
    logic             load;
    logic             at_check;
    logic [NUM_W-1:0] num;
    logic [NUM_W-1:0] num_next;
    crc4mf_state_e    state;

    // Qualify frame events with basic alignment.
    always_comb begin
        restart     = !basic_sync_i;
        step        = basic_sync_i && frame_strobe_i;
        nfas_strobe = step && frame_nfas_i;
        at_check    = (num_next == CHK_NUM);
    end

    crc4mf_bit_window #(
        .PAT_BITS (PAT_BITS),
        .PATTERN  (PATTERN),
        .FILL_W   (FILL_W)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart),
        .shift_i (nfas_strobe),
        .bit_i   (ts0_bit1_i),
        .hit_o   (win_hit)
    );

    crc4mf_frame_ctr #(
        .MF_FRAMES (MF_FRAMES),
        .NUM_W     (NUM_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (restart),
        .step_i     (step),
        .load_i     (load),
        .load_val_i (CHK_NUM),
        .num_o      (num),
        .num_next_o (num_next)
    );

    crc4mf_align_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (restart),
        .hit_i         (win_hit),
        .nfas_strobe_i (nfas_strobe),
        .at_check_i    (at_check),
        .load_o        (load),
        .pulse_o       (mf_pattern_pulse_o),
        .sync_n_o      (crc_sync_n_o),
        .state_o       (state)
    );

    assign mf_frame_num_o = 4'(num);

    // R1/R8: without basic alignment the outputs sit idle.
    p_unaligned_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !basic_sync_i |=> (crc_sync_n_o && mf_frame_num_o == 4'd0 && !mf_pattern_pulse_o));

    // R3: every marker pulse coincides with frame 11 on the counter.
    p_pulse_at_check_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pattern_pulse_o |-> (num == CHK_NUM));

    // R4: the frame number holds between strobes.
    p_num_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (basic_sync_i && !frame_strobe_i) |=> $stable(mf_frame_num_o));

    // R5: sync is only declared together with an accepted marker.
    p_lock_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_sync_n_o) |-> mf_pattern_pulse_o);

    // R7: the pulse lasts one cycle and follows a non-alignment strobe.
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pattern_pulse_o |=> !mf_pattern_pulse_o);

    p_pulse_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pattern_pulse_o |-> $past(frame_strobe_i && frame_nfas_i));

    // R10: lock is kept while basic alignment holds.
    p_lock_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_sync_n_o && basic_sync_i) |=> !crc_sync_n_o);

    // R5: the sync flag agrees with the locked state.
    p_sync_matches_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) == !crc_sync_n_o);

endmodule

// File: tb/crc4mf_detector_bench.sv
`timescale 1ns/1ps
// Directed bench for crc4mf_detector: one task per scenario.
module crc4mf_detector_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bsync = 1'b0;
    logic       strobe = 1'b0;
    logic       nfas = 1'b0;
    logic       bitv = 1'b0;
    logic       sync_n;
    logic [3:0] fnum;
    logic       pulse;

    int checks = 0;
    int bad = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    logic       s_sync_n;
    logic [3:0] s_num;
    logic       s_pulse;
    logic       s_pulse_after;

    localparam logic [5:0] MARK = 6'b001011;

    always #2 clk = ~clk;

    crc4mf_detector u_crc4mf_detector (
        .clk                (clk),
        .rst_n              (rst_n),
        .basic_sync_i       (bsync),
        .frame_strobe_i     (strobe),
        .frame_nfas_i       (nfas),
        .ts0_bit1_i         (bitv),
        .crc_sync_n_o       (sync_n),
        .mf_frame_num_o     (fnum),
        .mf_pattern_pulse_o (pulse)
    );

    always @(posedge clk) if (pulse) pulse_cnt <= pulse_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected timeslot-0 bit 1 for frame k; corrupt flips one marker bit.
    function automatic logic frame_bit(input int k, input int corrupt, input logic fas_bit);
        logic b;
        if (k % 2 == 0) b = fas_bit;
        else if (k <= 11) b = MARK[5 - (k - 1) / 2];
        else b = 1'b1;
        if (k == corrupt) b = ~b;
        return b;
    endfunction

    // One frame: strobe, then sample outputs, then sample the pulse again.
    task automatic send_frame(input int k, input logic b);
        @(negedge clk);
        strobe = 1'b1; nfas = logic'(k % 2); bitv = b;
        @(negedge clk);
        strobe = 1'b0;
        s_sync_n = sync_n; s_num = fnum; s_pulse = pulse;
        @(negedge clk);
        s_pulse_after = pulse;
    endtask

    task automatic send_mf(input int first, input int last, input int corrupt,
                           input logic fas_bit, input bit chk_num);
        for (int k = first; k <= last; k++) begin
            send_frame(k, frame_bit(k, corrupt, fas_bit));
            if (chk_num) check(s_num == 4'(k), "R4 frame number", int'(s_num), k);
        end
    endtask

    // Frames 12..15 then 0..11 of the next multiframe.
    task automatic send_wrap(input int corrupt, input logic fas_bit, input bit chk_num);
        send_mf(12, 15, -1, fas_bit, chk_num);
        send_mf(0, 11, corrupt, fas_bit, chk_num);
    endtask

    task automatic t_reset();
        check(sync_n == 1'b1, "R1 sync_n after reset", int'(sync_n), 1);
        check(fnum == 4'd0, "R1 frame number after reset", int'(fnum), 0);
        check(pulse == 1'b0, "R1 pulse after reset", int'(pulse), 0);
    endtask

    task automatic t_unaligned();
        int base = pulse_cnt;
        send_mf(0, 15, -1, 1'b1, 1'b0);
        send_mf(0, 15, -1, 1'b1, 1'b0);
        check(s_sync_n == 1'b1, "R1 sync_n while unaligned", int'(s_sync_n), 1);
        check(s_num == 4'd0, "R1 frame number while unaligned", int'(s_num), 0);
        check(pulse_cnt == base, "R1 no pulse while unaligned", pulse_cnt - base, 0);
    endtask

    task automatic t_acquire();
        int base;
        @(negedge clk); bsync = 1'b1;
        send_mf(4, 15, -1, 1'b1, 1'b0);
        check(s_num == 4'd12, "R4 count before re-phase", int'(s_num), 12);
        base = pulse_cnt;
        send_mf(0, 10, -1, 1'b1, 1'b0);
        check(s_num == 4'd7, "R4 count just before candidate", int'(s_num), 7);
        check(pulse_cnt == base, "R3 no early candidate", pulse_cnt - base, 0);
        send_frame(11, frame_bit(11, -1, 1'b1));
        check(s_num == 4'd11, "R3 re-phased to frame 11", int'(s_num), 11);
        check(s_pulse == 1'b1, "R7 pulse on candidate", int'(s_pulse), 1);
        check(s_pulse_after == 1'b0, "R7 pulse one cycle wide", int'(s_pulse_after), 0);
        check(s_sync_n == 1'b1, "R5 no sync after one marker", int'(s_sync_n), 1);
        // Alignment-frame bits are 0 here instead of 1: they must not matter.
        send_wrap(-1, 1'b0, 1'b1);
        check(s_sync_n == 1'b0, "R5 sync after second marker (R2 FAS bits ignored)", int'(s_sync_n), 0);
        check(s_pulse == 1'b1, "R7 pulse on confirmation", int'(s_pulse), 1);
    endtask

    task automatic t_locked_error();
        send_wrap(5, 1'b1, 1'b1);
        check(s_sync_n == 1'b0, "R10 lock kept on errored marker", int'(s_sync_n), 0);
        check(s_pulse == 1'b0, "R10 no pulse on errored marker", int'(s_pulse), 0);
        send_wrap(-1, 1'b1, 1'b0);
        check(s_pulse == 1'b1, "R7 pulse while locked", int'(s_pulse), 1);
        check(s_sync_n == 1'b0, "R10 still locked", int'(s_sync_n), 0);
    endtask

    task automatic t_loss();
        @(negedge clk); bsync = 1'b0;
        @(negedge clk);
        check(sync_n == 1'b1, "R8 sync cleared on loss", int'(sync_n), 1);
        check(fnum == 4'd0, "R8 frame number cleared on loss", int'(fnum), 0);
        bsync = 1'b1;
    endtask

    task automatic t_short_history();
        int base = pulse_cnt;
        // Five odd-frame bits 0,1,0,1,1 would match a zero-filled window.
        send_frame(3, 1'b0); send_frame(4, 1'b1);
        send_frame(5, 1'b1); send_frame(6, 1'b1);
        send_frame(7, 1'b0); send_frame(8, 1'b1);
        send_frame(9, 1'b1); send_frame(10, 1'b1);
        send_frame(11, 1'b1);
        check(pulse_cnt == base, "R9 no candidate from short history", pulse_cnt - base, 0);
        check(s_sync_n == 1'b1, "R9 no sync from short history", int'(s_sync_n), 1);
    endtask

    task automatic t_confirm_fail();
        send_wrap(-1, 1'b1, 1'b0);
        check(s_pulse == 1'b1, "R3 fresh candidate after restart", int'(s_pulse), 1);
        check(s_num == 4'd11, "R3 frame number on fresh candidate", int'(s_num), 11);
        send_wrap(9, 1'b1, 1'b1);
        check(s_sync_n == 1'b1, "R6 no sync on errored confirmation", int'(s_sync_n), 1);
        check(s_pulse == 1'b0, "R6 no pulse on errored confirmation", int'(s_pulse), 0);
        send_wrap(-1, 1'b1, 1'b0);
        check(s_pulse == 1'b1, "R6 good marker taken as new candidate", int'(s_pulse), 1);
        check(s_sync_n == 1'b1, "R6 new candidate still unlocked", int'(s_sync_n), 1);
        send_wrap(-1, 1'b1, 1'b0);
        check(s_sync_n == 1'b0, "R5 lock after fresh confirmation", int'(s_sync_n), 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unaligned();
        t_acquire();
        t_locked_error();
        t_loss();
        t_short_history();
        t_confirm_fail();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule